// File: doc/BRIEF.md
# Instruction Fetch and Next-Address Unit

This block is the front end of a single-cycle processor datapath. It holds the 32-bit byte-addressed program counter, forms the sequential address (counter plus four), reads the 32-bit instruction word at the current counter from a local word-addressed instruction store, and chooses the address loaded into the counter on the next rising clock edge. The choice is made by two control inputs supplied by a control unit elsewhere. The sequential address is one choice. A relative branch target is another: the sequential address plus four times the sign-extended 16-bit immediate. The third choice is an absolute jump address built from the low 26 instruction bits.

The byte counter is turned into a 24-bit word index by shifting right two places and then keeping only the low 24 bits. The store holds the low `2**MEM_AW` words of that index space, so higher indices alias onto it. The store is filled through a write port, normally while the block is held in reset. One sign extender feeds both the branch adder and the exported immediate, which other datapath blocks use as an operand.

Top module: `ifetch_unit`

## Requirements
- R1: While `rst_n` is low the program counter `pc` is 0; the reset acts without waiting for a clock edge.
- R2: `pc_plus4` always equals `pc + 4` modulo 2^32, so 0xFFFFFFFC gives 0.
- R3: With `jump` = 0 and `pc_src` = 0, the next rising edge loads `pc_plus4` into `pc`.
- R4: With `jump` = 0 and `pc_src` = 1, the next rising edge loads `pc_plus4 + 4*imm_ext` modulo 2^32. Negative immediates move the counter backwards.
- R5: With `jump` = 1, the next rising edge loads {`pc_plus4`[31:28], `instr`[25:0], 2'b00}, whatever the value of `pc_src`.
- R6: `imm_ext` is `instr`[15:0] with bit 15 copied into bits 31:16.
- R7: `word_idx` equals `pc`[25:2], and `instr` is the stored word at entry `word_idx` mod 2^MEM_AW. `pc` bits 1:0 and 31:26 have no effect on the fetch.
- R8: When `load_en` is 1 at a rising edge, `load_data` is written to entry `load_addr`. From that edge on, `instr` shows the new word whenever the current `word_idx` selects that entry. Writes also take place while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the counter |
| pc_src | input | 1 | 1 selects the branch target, 0 the sequential address |
| jump | input | 1 | 1 selects the jump address, overriding `pc_src` |
| load_en | input | 1 | Write strobe for the instruction store |
| load_addr | input | MEM_AW | Store entry to write |
| load_data | input | 32 | Word to write |
| pc | output | 32 | Current program counter (byte address) |
| pc_plus4 | output | 32 | Sequential address |
| word_idx | output | 24 | Truncated word index used for the fetch |
| instr | output | 32 | Fetched instruction word |
| imm_ext | output | 32 | Sign-extended immediate field |

## Verification
The properties on the counter's next value assume that `pc_src` and `jump` are steady around each rising edge and that `rst_n` is released away from an edge. The bench therefore changes every control and load input only on the falling edge. The sign-extension check assumes the instruction store has been filled, so it is skipped while the fetched word is unknown. The bench loads every entry during reset, before the first fetch. The write property expects that no second write hits the same entry in the following cycle, and the bench's single mid-run write respects that.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
  localparam int XLEN   = 32;
  localparam int IMM_W  = 16;
  localparam int TGT_W  = 26;
  localparam int IDX_W  = 24;
  localparam int ALIGN  = 2;
  localparam int HI_W   = XLEN - TGT_W - ALIGN;

  typedef logic [XLEN-1:0] word_t;

  typedef enum logic [1:0] {
    SEL_SEQ    = 2'd0,
    SEL_BRANCH = 2'd1,
    SEL_JUMP   = 2'd2
  } npc_sel_e;
endpackage

// File: rtl/ifu_sext.sv
module ifu_sext
  import ifu_pkg::*;
(
  input  logic [IMM_W-1:0] imm_i,
  output word_t            imm_o
);
  always_comb begin
    imm_o = {{(XLEN-IMM_W){imm_i[IMM_W-1]}}, imm_i};
  end

  // R6: the low field passes through and the upper bits all match the sign
  always_comb begin
    if (!$isunknown(imm_i)) begin
      a_r6_sign_fill: assert (imm_o[IMM_W-1:0] == imm_i &&
        ($countones(imm_o[XLEN-1:IMM_W-1]) == 0 ||
         $countones(imm_o[XLEN-1:IMM_W-1]) == XLEN-IMM_W+1));
    end
  end
endmodule

// File: rtl/ifu_next_pc.sv
module ifu_next_pc
  import ifu_pkg::*;
(
  input  word_t            pc4_i,
  input  word_t            imm_i,
  input  logic [TGT_W-1:0] tgt_i,
  input  logic             pc_src_i,
  input  logic             jump_i,
  output word_t            npc_o
);
  npc_sel_e sel;
  word_t    br_tgt;
  word_t    jmp_tgt;

  always_comb begin
    if (jump_i)        sel = SEL_JUMP;
    else if (pc_src_i) sel = SEL_BRANCH;
    else               sel = SEL_SEQ;
  end

  always_comb begin
    br_tgt  = pc4_i + {imm_i[XLEN-1-ALIGN:0], {ALIGN{1'b0}}};
    jmp_tgt = {pc4_i[XLEN-1 -: HI_W], tgt_i, {ALIGN{1'b0}}};
  end

  always_comb begin
    unique case (sel)
      SEL_JUMP:   npc_o = jmp_tgt;
      SEL_BRANCH: npc_o = br_tgt;
      default:    npc_o = pc4_i;
    endcase
  end
endmodule

// File: rtl/ifu_pc_reg.sv
module ifu_pc_reg
  import ifu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en_i,
  input  word_t npc_i,
  output word_t pc_o
);
  word_t pc_q;
  word_t pc_d;

  always_comb begin
    pc_d = pc_q;
    if (en_i) pc_d = npc_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/ifu_imem.sv
module ifu_imem
  import ifu_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [MEM_AW-1:0] load_addr,
  input  word_t             load_data,
  input  logic [MEM_AW-1:0] rd_addr,
  output word_t             rd_data
);
  localparam int DEPTH = 1 << MEM_AW;

  word_t mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (load_en) mem_q[load_addr] <= load_data;
  end

  assign rd_data = mem_q[rd_addr];

  // R8: a write lands in the addressed entry at the strobe edge
  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> mem_q[$past(load_addr)] == $past(load_data));
endmodule

// File: rtl/ifetch_unit.sv
module ifetch_unit
  import ifu_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pc_src,
  input  logic              jump,
  input  logic              load_en,
  input  logic [MEM_AW-1:0] load_addr,
  input  logic [31:0]       load_data,
  output logic [31:0]       pc,
  output logic [31:0]       pc_plus4,
  output logic [23:0]       word_idx,
  output logic [31:0]       instr,
  output logic [31:0]       imm_ext
);
  word_t npc;
  word_t pc_shr;

  generate
    if (MEM_AW > IDX_W || MEM_AW < 1) begin : g_bad_aw
      initial $error("MEM_AW must lie in 1..IDX_W");
    end
  endgenerate

  ifu_pc_reg u_pc (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (1'b1),
    .npc_i (npc),
    .pc_o  (pc)
  );

  always_comb begin
    pc_plus4 = pc + XLEN'(4);
    pc_shr   = pc >> ALIGN;
    word_idx = pc_shr[IDX_W-1:0];
  end

  ifu_imem #(.MEM_AW(MEM_AW)) u_imem (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_addr (load_addr),
    .load_data (load_data),
    .rd_addr   (word_idx[MEM_AW-1:0]),
    .rd_data   (instr)
  );

  ifu_sext u_sext (
    .imm_i (instr[IMM_W-1:0]),
    .imm_o (imm_ext)
  );

  ifu_next_pc u_npc (
    .pc4_i    (pc_plus4),
    .imm_i    (imm_ext),
    .tgt_i    (instr[TGT_W-1:0]),
    .pc_src_i (pc_src),
    .jump_i   (jump),
    .npc_o    (npc)
  );

  // R3: sequential step lands on the previous sequential address
  a_r3_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!jump && !pc_src) |=> pc == $past(pc_plus4));

  // R4: relative branch offset is four times the exported immediate
  a_r4_branch_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!jump && pc_src) |=> (pc - $past(pc_plus4)) == {$past(imm_ext[29:0]), 2'b00});

  // R5: jump keeps the upper nibble and places the target field
  a_r5_jump_step: assert property (@(posedge clk) disable iff (!rst_n)
    jump |=> (pc[27:0] == {$past(instr[25:0]), 2'b00}) &&
             (pc[31:28] == $past(pc_plus4[31:28])));
endmodule

// File: tb/ifetch_unit_tb.sv
module ifetch_unit_tb;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  typedef struct packed {
    logic [31:0] pc;
    logic [31:0] pc4;
    logic [23:0] idx;
    logic [31:0] ins;
    logic [31:0] imm;
    logic [1:0]  mode;   // 0 seq, 1 branch, 2 jump
    logic        loaded;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pc_src = 1'b0, jump = 1'b0, load_en = 1'b0;
  logic [AW-1:0] load_addr = '0;
  logic [31:0] load_data = '0;
  logic [31:0] pc, pc_plus4, instr, imm_ext;
  logic [23:0] word_idx;

  int n_chk = 0;
  int n_bad = 0;
  exp_t q[$];
  logic [31:0] mdl_mem [DEPTH];
  logic [31:0] mdl_pc;

  always #10 clk = ~clk;

  ifetch_unit #(.MEM_AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pc_src(pc_src), .jump(jump),
    .load_en(load_en), .load_addr(load_addr), .load_data(load_data),
    .pc(pc), .pc_plus4(pc_plus4), .word_idx(word_idx),
    .instr(instr), .imm_ext(imm_ext)
  );

  function automatic logic [23:0] f_idx(logic [31:0] p);
    logic [31:0] s;
    s = p >> 2;
    return s[23:0];
  endfunction

  function automatic logic [31:0] f_sext(logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // driver: called at a falling edge, returns at the next falling edge
  task automatic step(logic src, logic jmp, logic ld_next, logic [31:0] ld_word);
    logic [31:0] cur_ins, p4, np;
    logic [23:0] ni;
    exp_t e;
    cur_ins = mdl_mem[f_idx(mdl_pc) % DEPTH];
    p4 = mdl_pc + 32'd4;
    if (jmp)      np = {p4[31:28], cur_ins[25:0], 2'b00};
    else if (src) np = p4 + {f_sext(cur_ins[15:0]), 2'b00};
    else          np = p4;
    ni = f_idx(np);
    pc_src = src;
    jump = jmp;
    load_en = ld_next;
    load_addr = ni[AW-1:0];
    load_data = ld_word;
    if (ld_next) mdl_mem[ni[AW-1:0]] = ld_word;
    mdl_pc = np;
    e.pc = np;
    e.pc4 = np + 32'd4;
    e.idx = ni;
    e.ins = mdl_mem[ni[AW-1:0]];
    e.imm = f_sext(e.ins[15:0]);
    e.mode = jmp ? 2'd2 : (src ? 2'd1 : 2'd0);
    e.loaded = ld_next;
    q.push_back(e);
    @(negedge clk);
    load_en = 1'b0;
  endtask

  // monitor
  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      case (e.mode)
        2'd2:    check("R5 jump pc", pc, e.pc);
        2'd1:    check("R4 branch pc", pc, e.pc);
        default: check("R3 sequential pc", pc, e.pc);
      endcase
      check("R2 pc_plus4", pc_plus4, e.pc4);
      check("R7 word_idx", {8'h00, word_idx}, {8'h00, e.idx});
      check(e.loaded ? "R8 loaded instr" : "R7 instr", instr, e.ins);
      check("R6 imm_ext", imm_ext, e.imm);
    end
  end

  initial begin
    #(200000 * 20);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mdl_mem[i] = i * 32'h9E3779B1 + 32'h0000_1234;
    mdl_mem[0]   = 32'h1000_FFFE;   // branch -2 from pc 0 -> 0xFFFFFFFC
    mdl_mem[255] = 32'h1000_FFFE;   // from 0xFFFFFFFC: pc4 wraps to 0, -> 0xFFFFFFF8
    mdl_mem[254] = 32'h0800_0020;   // jump, upper nibble F -> 0xF0000080
    mdl_mem[16]  = 32'h1000_0003;
    mdl_mem[1]   = 32'h0800_0010;
    mdl_pc = '0;
    // R8: preload while held in reset
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      load_en = 1'b1;
      load_addr = i[AW-1:0];
      load_data = mdl_mem[i];
    end
    @(negedge clk);
    load_en = 1'b0;
    check("R1 reset pc", pc, 32'h0);
    check("R7 instr at reset", instr, mdl_mem[0]);
    check("R6 imm at reset", imm_ext, 32'hFFFF_FFFE);
    rst_n = 1'b1;
    step(1'b1, 1'b0, 1'b0, 32'h0);   // R4 negative branch wraps below 0
    step(1'b1, 1'b0, 1'b0, 32'h0);   // R2 wrap of pc_plus4, R4
    step(1'b1, 1'b1, 1'b0, 32'h0);   // R5 jump overrides pc_src, R7 upper bits dropped
    step(1'b0, 1'b0, 1'b0, 32'h0);
    step(1'b0, 1'b0, 1'b0, 32'h0);
    step(1'b1, 1'b0, 1'b0, 32'h0);
    step(1'b0, 1'b1, 1'b0, 32'h0);
    for (int i = 0; i < 60; i++) begin
      step((i % 3) == 0, (i % 7) == 3, i == 20, 32'hA5C3_0011 + i);
    end
    while (q.size() > 0) @(negedge clk);
    // R1: reset acts without a clock edge
    #2;
    rst_n = 1'b0;
    #1;
    check("R1 async reset pc", pc, 32'h0);
    check("R2 pc_plus4 after reset", pc_plus4, 32'h4);
    @(negedge clk);
    finish_run();
  end
endmodule